// File: doc/BRIEF.md
# Bit Field Extraction Unit

This unit takes a 32-bit scene word and a 16-bit control word, and returns a contiguous run of scene bits moved down so that the lowest selected bit lands at result bit 0. The control word holds two 5-bit fields: a start position and a field length. A mode input chooses what fills the result above the field. In zero mode those bits are cleared. In sign mode they copy the top bit of the extracted field.

A request is presented with `valid_in`. One clock later, `valid_out` rises together with the registered result and four status flags. Requested bits that lie above scene bit 31 always read as zero. The zero and negative flags describe the result. The carry and overflow flags are always cleared by an operation.

Top module: `bfx_unit`

## Requirements
- R1: The start position p is taken from control bits 12:8 and the length L from control bits 4:0. Control bits 15:13 and 7:5 have no effect on any output.
- R2: Result bit i, for i below L, equals scene bit p+i.
- R3: When p+L exceeds 32, every requested bit whose scene index is above 31 reads as zero.
- R4: In zero mode (`sign_ext`=0), every result bit at index L or above is 0.
- R5: In sign mode (`sign_ext`=1), every result bit at index L or above equals result bit L-1.
- R6: When L is 0, the result is all zeros in both modes and the zero flag is set.
- R7: In sign mode, when scene index p+L-1 is above 31, the fill bits are zero.
- R8: `flag_zero` is 1 exactly when the registered result is all zeros.
- R9: `flag_neg` equals bit 31 of the registered result.
- R10: `flag_carry` and `flag_ovf` read 0 after every operation.
- R11: `valid_out` is `valid_in` delayed by one clock. The result and the flags load only on a cycle with `valid_in` high and otherwise hold their values.
- R12: A synchronous active-high `rst` clears `valid_out`, `result` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request strobe |
| scene_in | input | 32 | Word the field is taken from |
| ctrl_in | input | 16 | Packed control: position in bits 12:8, length in bits 4:0 |
| sign_ext | input | 1 | 1 selects sign fill, 0 selects zero fill |
| valid_out | output | 1 | Result and flags are fresh |
| result | output | 32 | Right-justified extracted field |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 31 |
| flag_carry | output | 1 | Carry flag, always cleared |
| flag_ovf | output | 1 | Overflow flag, always cleared |

## Verification
The hardest case to reach is a field that runs past the top of the scene in sign mode. In that case the bit that would give the sign lies outside the word, so the fill must come out as zeros even when scene bit 31 is set. The stimulus reaches it with a directed vector whose position plus length goes beyond 32. A full sweep of every position and length in both modes, over several scene words including all-ones, then checks it again against a reference model that builds the result bit by bit.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   typedef enum logic {
      BFX_FILL_ZERO = 1'b0,
      BFX_FILL_SIGN = 1'b1
   } bfx_fill_e;

   typedef struct packed {
      logic zero;
      logic neg;
      logic carry;
      logic ovf;
   } bfx_flags_t;

   function automatic bfx_flags_t bfx_make_flags(input logic is_zero, input logic top_bit);
      bfx_flags_t f;
      f.zero  = is_zero;
      f.neg   = top_bit;
      f.carry = 1'b0;
      f.ovf   = 1'b0;
      return f;
   endfunction

endpackage

// File: rtl/bfx_ctrl_decode.sv
module bfx_ctrl_decode #(
   parameter int CTRL_W  = 16,
   parameter int IDX_W   = 5,
   parameter int POS_LSB = 8,
   parameter int LEN_LSB = 0
) (
   input  logic [CTRL_W-1:0] ctrl,
   output logic [IDX_W-1:0]  pos,
   output logic [IDX_W-1:0]  len
);

   initial begin
      if (POS_LSB + IDX_W > CTRL_W) $error("position field exceeds control word");
      if (LEN_LSB + IDX_W > CTRL_W) $error("length field exceeds control word");
   end

   assign pos = ctrl[POS_LSB +: IDX_W];
   assign len = ctrl[LEN_LSB +: IDX_W];

endmodule

// File: rtl/bfx_shift_right.sv
module bfx_shift_right #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5,
   parameter bit BARREL = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  amt,
   output logic [DATA_W-1:0] dout
);

   initial begin
      if ((1 << IDX_W) != DATA_W) $error("DATA_W must equal 2**IDX_W");
   end

   generate
      if (BARREL) begin : g_barrel
         logic [DATA_W-1:0] stage [IDX_W+1];
         assign stage[0] = din;
         for (genvar s = 0; s < IDX_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = amt[s] ? {{SH{1'b0}}, stage[s][DATA_W-1:SH]} : stage[s];
         end
         assign dout = stage[IDX_W];
      end else begin : g_operator
         assign dout = din >> amt;
      end
   endgenerate

endmodule

// File: rtl/bfx_field_fit.sv
module bfx_field_fit
   import bfx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic [DATA_W-1:0] shifted,
   input  logic [IDX_W-1:0]  len,
   input  bfx_fill_e         fill,
   output logic [DATA_W-1:0] fitted
);

   logic [DATA_W-1:0] keep_mask;
   logic [IDX_W-1:0]  top_idx;
   logic              top_bit;
   logic              fill_bit;

   assign keep_mask = ~({DATA_W{1'b1}} << len);
   assign top_idx   = len - IDX_W'(1);
   assign top_bit   = (len != '0) ? shifted[top_idx] : 1'b0;
   assign fill_bit  = (fill == BFX_FILL_SIGN) ? top_bit : 1'b0;

   always_comb begin
      fitted = (shifted & keep_mask) | ({DATA_W{fill_bit}} & ~keep_mask);
   end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CTRL_W  = 16,
   parameter int POS_LSB = 8,
   parameter int LEN_LSB = 0,
   parameter bit BARREL  = 1'b1,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic [DATA_W-1:0] scene_in,
   input  logic [CTRL_W-1:0] ctrl_in,
   input  logic              sign_ext,
   output logic              valid_out,
   output logic [DATA_W-1:0] result,
   output logic              flag_zero,
   output logic              flag_neg,
   output logic              flag_carry,
   output logic              flag_ovf
);

   initial begin
      if (DATA_W < 2) $error("DATA_W too small");
   end

   logic [IDX_W-1:0]  pos;
   logic [IDX_W-1:0]  len;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] fitted;
   bfx_fill_e         fill;
   bfx_flags_t        flags_d;
   bfx_flags_t        flags_q;

   assign fill = sign_ext ? BFX_FILL_SIGN : BFX_FILL_ZERO;

   bfx_ctrl_decode #(
      .CTRL_W (CTRL_W),
      .IDX_W  (IDX_W),
      .POS_LSB(POS_LSB),
      .LEN_LSB(LEN_LSB)
   ) i_decode (
      .ctrl(ctrl_in),
      .pos (pos),
      .len (len)
   );

   bfx_shift_right #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W),
      .BARREL(BARREL)
   ) i_shift (
      .din (scene_in),
      .amt (pos),
      .dout(shifted)
   );

   bfx_field_fit #(
      .DATA_W(DATA_W),
      .IDX_W (IDX_W)
   ) i_fit (
      .shifted(shifted),
      .len    (len),
      .fill   (fill),
      .fitted (fitted)
   );

   assign flags_d = bfx_make_flags(fitted == '0, fitted[DATA_W-1]);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out <= 1'b0;
         result    <= '0;
         flags_q   <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            result  <= fitted;
            flags_q <= flags_d;
         end
      end
   end

   assign flag_zero  = flags_q.zero;
   assign flag_neg   = flags_q.neg;
   assign flag_carry = flags_q.carry;
   assign flag_ovf   = flags_q.ovf;

endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int CTRL_W  = 16,
   parameter int POS_LSB = 8,
   parameter int LEN_LSB = 0,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_in,
   input logic [DATA_W-1:0] scene_in,
   input logic [CTRL_W-1:0] ctrl_in,
   input logic              sign_ext,
   input logic              valid_out,
   input logic [DATA_W-1:0] result,
   input logic              flag_zero,
   input logic              flag_neg,
   input logic              flag_carry,
   input logic              flag_ovf
);

   logic [IDX_W-1:0] c_pos;
   logic [IDX_W-1:0] c_len;
   logic [IDX_W:0]   c_end;
   logic             c_run_over;

   assign c_pos      = ctrl_in[POS_LSB +: IDX_W];
   assign c_len      = ctrl_in[LEN_LSB +: IDX_W];
   assign c_end      = {1'b0, c_pos} + {1'b0, c_len};
   assign c_run_over = c_end > (IDX_W+1)'(DATA_W);

   // R11: handshake latency
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
   a_r11_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);
   a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> ($stable(result) && $stable(flag_zero) && $stable(flag_neg)));

   // R4: zero fill above the field
   a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !sign_ext) |=> ((result >> $past(c_len)) == '0));

   // R5: sign fill above the field is uniform
   a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
      (valid_in && sign_ext && c_len != '0) |=>
         (((result >> $past(c_len)) == '0) ||
          ((result >> $past(c_len)) == ({DATA_W{1'b1}} >> $past(c_len)))));

   // R6: empty field
   a_r6_empty_field: assert property (@(posedge clk) disable iff (rst)
      (valid_in && c_len == '0) |=> (result == '0 && flag_zero));

   // R3: bits past the scene top read zero (zero mode)
   a_r3_top_zero: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !sign_ext && c_run_over) |=>
         ((result >> (DATA_W - $past(c_pos))) == '0));

   // R7: sign taken from beyond the scene is zero
   a_r7_no_ones: assert property (@(posedge clk) disable iff (rst)
      (valid_in && sign_ext && c_run_over) |=> !result[DATA_W-1]);

   // R8, R9: flags describe the result
   a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> (flag_zero == (result == '0)));
   a_r9_neg_flag: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> (flag_neg == result[DATA_W-1]));

   // R10: carry and overflow cleared
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
      valid_out |-> (!flag_carry && !flag_ovf));

   // R12: reset state
   a_r12_reset_clear: assert property (@(posedge clk)
      rst |=> (!valid_out && result == '0 && !flag_zero && !flag_neg && !flag_carry && !flag_ovf));

   // R1: field decode uses only the documented bits (scene unchanged, ignored bits flipped)
   a_r1_ignored_bits: assert property (@(posedge clk) disable iff (rst)
      (valid_in && $past(valid_in) && $stable(scene_in) && $stable(sign_ext) &&
       $stable(c_pos) && $stable(c_len)) |=> $stable(result));

endmodule

bind bfx_unit bfx_unit_chk #(
   .DATA_W (DATA_W),
   .CTRL_W (CTRL_W),
   .POS_LSB(POS_LSB),
   .LEN_LSB(LEN_LSB)
) i_bfx_unit_chk (
   .clk       (clk),
   .rst       (rst),
   .valid_in  (valid_in),
   .scene_in  (scene_in),
   .ctrl_in   (ctrl_in),
   .sign_ext  (sign_ext),
   .valid_out (valid_out),
   .result    (result),
   .flag_zero (flag_zero),
   .flag_neg  (flag_neg),
   .flag_carry(flag_carry),
   .flag_ovf  (flag_ovf)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;

   localparam int NV = 13;

   // R2, R5, R4, R5, R1, R7, R3, R2, R9, R5, R6, R8, R5
   localparam logic [31:0] V_SCENE [NV] = '{
      32'hA5A5C3AA, 32'hA5A5C3AA, 32'hA5A5C3AA, 32'hA5A5C3AA,
      32'hA5A5C3AA, 32'hA5A5C3AA, 32'hA5A5C3AA, 32'hA5A5C3AA,
      32'h80000000, 32'h80000000, 32'hFFFFFFFF, 32'h00000000,
      32'h000000E0};
   localparam logic [15:0] V_CTRL [NV] = '{
      16'h0704, 16'h0704, 16'h0D09, 16'h0D09,
      16'hEDE9, 16'h1C08, 16'h1C08, 16'h001F,
      16'h1F01, 16'h1010, 16'h0500, 16'h0314,
      16'h0503};
   localparam logic V_SIGN [NV] = '{
      1'b0, 1'b1, 1'b0, 1'b1,
      1'b0, 1'b1, 1'b0, 1'b1,
      1'b1, 1'b1, 1'b1, 1'b0,
      1'b1};
   localparam logic [31:0] V_EXP [NV] = '{
      32'h00000007, 32'h00000007, 32'h0000012E, 32'hFFFFFF2E,
      32'h0000012E, 32'h0000000A, 32'h0000000A, 32'h25A5C3AA,
      32'hFFFFFFFF, 32'hFFFF8000, 32'h00000000, 32'h00000000,
      32'hFFFFFFFF};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_in = 1'b0;
   logic [31:0] scene_in = '0;
   logic [15:0] ctrl_in = '0;
   logic        sign_ext = 1'b0;
   logic        valid_out;
   logic [31:0] result;
   logic        flag_zero, flag_neg, flag_carry, flag_ovf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string vreq [NV];

   always #2.5 clk = ~clk;

   bfx_unit i_bfx_unit (
      .clk       (clk),
      .rst       (rst),
      .valid_in  (valid_in),
      .scene_in  (scene_in),
      .ctrl_in   (ctrl_in),
      .sign_ext  (sign_ext),
      .valid_out (valid_out),
      .result    (result),
      .flag_zero (flag_zero),
      .flag_neg  (flag_neg),
      .flag_carry(flag_carry),
      .flag_ovf  (flag_ovf)
   );

   function automatic logic [31:0] model(input logic [31:0] sc, input logic [15:0] cw, input logic sx);
      int p = int'(cw[12:8]);
      int l = int'(cw[4:0]);
      logic [31:0] r = '0;
      logic fb = 1'b0;
      for (int i = 0; i < 32; i++) begin
         if (i < l && (p + i) < 32) r[i] = sc[p + i];
      end
      if (sx && l > 0) fb = r[l - 1];
      for (int i = 0; i < 32; i++) begin
         if (i >= l) r[i] = fb;
      end
      return r;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] sc, input logic [15:0] cw, input logic sx);
      @(negedge clk);
      scene_in = sc;
      ctrl_in  = cw;
      sign_ext = sx;
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   task automatic check_outputs(input string req, input logic [31:0] exp);
      check(req, "result", result, exp);
      check("R8", "flag_zero", 32'(flag_zero), 32'(exp == 32'h0));
      check("R9", "flag_neg", 32'(flag_neg), 32'(exp[31]));
      check("R10", "flag_carry/ovf", {30'h0, flag_carry, flag_ovf}, 32'h0);
      check("R11", "valid_out", 32'(valid_out), 32'h1);
   endtask

   initial begin
      vreq = '{"R2", "R5", "R4", "R5", "R1", "R7", "R3", "R2", "R9", "R5", "R6", "R8", "R5"};
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", "valid_out", 32'(valid_out), 32'h0);
      check("R12", "result", result, 32'h0);
      check("R12", "flags", {28'h0, flag_zero, flag_neg, flag_carry, flag_ovf}, 32'h0);
      rst = 1'b0;

      for (int v = 0; v < NV; v++) begin
         run_op(V_SCENE[v], V_CTRL[v], V_SIGN[v]);
         check_outputs(vreq[v], V_EXP[v]);
      end

      // R11: no request -> outputs hold, valid_out low
      run_op(32'hA5A5C3AA, 16'h0D09, 1'b1);
      @(negedge clk);
      scene_in = 32'h12345678;
      ctrl_in  = 16'h0004;
      sign_ext = 1'b0;
      @(negedge clk);
      check("R11", "held result", result, 32'hFFFFFF2E);
      check("R11", "idle valid_out", 32'(valid_out), 32'h0);
      check("R11", "held flag_neg", 32'(flag_neg), 32'h1);

      // R1: ignored control bits give the same answer
      run_op(32'h5A5AF00F, 16'hE0E6, 1'b1);
      check("R1", "ignored bits set", result, model(32'h5A5AF00F, 16'h0006, 1'b1));

      // R6: length zero in sign mode with all-ones scene
      run_op(32'hFFFFFFFF, 16'h1F00, 1'b1);
      check("R6", "empty field", result, 32'h0);
      check("R6", "empty zero flag", 32'(flag_zero), 32'h1);

      // R7: field runs past scene top, scene bit 31 set
      run_op(32'hFFFFFFFF, 16'h1F1F, 1'b1);
      check("R7", "overrun sign", result, 32'h00000001);

      // R2, R3, R4, R5: full sweep against the bit-level model
      for (int s = 0; s < 3; s++) begin
         logic [31:0] sc;
         sc = (s == 0) ? 32'hA5A5C3AA : (s == 1) ? 32'hFFFFFFFF : 32'h8001_7E35;
         for (int p = 0; p < 32; p++) begin
            for (int l = 0; l < 32; l++) begin
               for (int m = 0; m < 2; m++) begin
                  logic [15:0] cw;
                  cw = {3'b000, 5'(p), 3'b000, 5'(l)};
                  run_op(sc, cw, m[0]);
                  check(m[0] ? "R5" : "R4", "sweep", result, model(sc, cw, m[0]));
               end
            end
         end
      end

      // R12: reset mid-stream clears outputs
      run_op(32'hFFFFFFFF, 16'h0010, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R12", "reset result", result, 32'h0);
      check("R12", "reset flags", {28'h0, flag_zero, flag_neg, flag_carry, flag_ovf}, 32'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule